// File: doc/BRIEF.md
# Debug trigger register bank

This block is the machine-mode register bank behind a hart's hardware debug triggers. It holds a trigger select register, three data words per trigger (control, compare address, extra context) and a read-only capability word. Software reaches it through a plain CSR port: address, write enable, write data, and a combinational read data output.

Every write is legalized before it is stored. Only control fields that the trigger type supports are kept. Unsupported size codes become the "any size" code. The context selector in the extra word folds to 0 or 4. Writes that would produce an unsupported trigger type are dropped. The stored control, address and extra words of every trigger are exported flat to the matching logic, which lives outside this block. Trigger `i` occupies bits `[i*XLEN +: XLEN]` of each export bus.

The layout follows the machine XLEN parameter (32 or 64). The trigger type is in the top four bits of the control word. The debug-mode bit sits just below it.

Top module: `dbg_trig_bank`

## Requirements
- R1: After reset the select register reads 0. Every trigger's control word is type 2 with all other bits zero (0x2000_0000 at XLEN 32). Its address and extra words are zero.
- R2: The select register is at CSR 0x7A0. A write of a value below NUM_TRIG selects that trigger. A write of a value at or above NUM_TRIG leaves the select register unchanged.
- R3: The capability word at CSR 0x7A4 always reads 0x44, which is bits 2 and 6 set. Writes to it have no effect.
- R4: A control write (CSR 0x7A1) with type 2 stores the following bits and zeroes the rest, including the debug-mode bit:
  - the type;
  - sizelo, bits 17:16;
  - sizehi, bits 22:21, at XLEN 64 only;
  - the mode bits 6, 4 and 3;
  - the execute, store and load bits 2, 1 and 0.
- R5: In a type 2 or type 6 control write, the size code is kept only if it is 0, 1, 2, 3 or 5. Otherwise it is stored as 0. For type 2 the code is {sizehi, sizelo}. For type 6 it is bits 19:16. A type 6 write also keeps bits 24:23 and the same mode and access bits as type 2.
- R6: A control write with type 3 keeps bits 26, 25, 23:10, 9, 7 and 6, and zeroes the rest. While a trigger holds type 3, writes to its address word (CSR 0x7A2) are ignored.
- R7: A control write whose type field is not 2, 3 or 6 leaves the selected trigger's control word unchanged.
- R8: An extra-word write (CSR 0x7A3) keeps the value field, stores the selector field with its low two bits cleared, and zeroes every other bit. At XLEN 32 the value field is bits 31:26 and the selector is bits 25:23. At XLEN 64 the value field is bits 63:51 and the selector is bits 50:48.
- R9: For type 2 and type 6 triggers, an address-word write is stored unchanged and read back in full.
- R10: Writes reach only the selected trigger. The export buses show each trigger's stored words.
- R11: Writes take effect at the clock edge. A write to the address or extra word in the cycle right after a control write is handled according to the type that the control write stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | Write enable |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data for csr_addr_i (combinational) |
| trig_ctrl_o | output | NUM_TRIG*XLEN | Stored control words |
| trig_addr_o | output | NUM_TRIG*XLEN | Stored address words |
| trig_extra_o | output | NUM_TRIG*XLEN | Stored extra-context words |

## Verification
A control write that changes a trigger's type, and the type-dependent handling of the next address write, can fall in adjacent cycles. The second write's legalization must then use the type that was just stored. The bench provokes this with back-to-back writes: a type 3 write followed at once by an address write, which must be ignored, and a type 2 write followed at once by an address write, which must be stored. A read issued in the next cycle judges the result against the value the requirements predict.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam logic [11:0] A_SEL  = 12'h7A0;
  localparam logic [11:0] A_CTRL = 12'h7A1;
  localparam logic [11:0] A_ADDR = 12'h7A2;
  localparam logic [11:0] A_EXTR = 12'h7A3;
  localparam logic [11:0] A_INFO = 12'h7A4;

  localparam logic [3:0] TT_ADDR  = 4'd2;
  localparam logic [3:0] TT_ICNT  = 4'd3;
  localparam logic [3:0] TT_ADDR6 = 4'd6;

  localparam logic [7:0] INFO_VAL = 8'h44;

  function automatic logic size_ok(input logic [3:0] c);
    return (c == 4'd0) || (c == 4'd1) || (c == 4'd2) || (c == 4'd3) || (c == 4'd5);
  endfunction

  function automatic int mhs_lo(input int xlen);
    return (xlen == 64) ? 48 : 23;
  endfunction

  function automatic int mhv_lo(input int xlen);
    return (xlen == 64) ? 51 : 26;
  endfunction
endpackage

// File: rtl/dbg_trig_legalize.sv
module dbg_trig_legalize
  import dbg_trig_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] ctrl_o,
  output logic            ctrl_ok_o,
  output logic [XLEN-1:0] extra_o
);
  localparam int MHS = mhs_lo(XLEN);
  localparam int MHV = mhv_lo(XLEN);

  logic [3:0]      wtype;
  logic [3:0]      size2, size6;
  logic [XLEN-1:0] c2, c6, c3;

  assign wtype = wdata_i[XLEN-1 -: 4];
  assign size6 = wdata_i[19:16];

  generate
    if (XLEN == 64) begin : g_x64
      assign size2 = {wdata_i[22:21], wdata_i[17:16]};
    end else begin : g_x32
      assign size2 = {2'b00, wdata_i[17:16]};
    end
  endgenerate

  always_comb begin
    c2 = '0;
    c2[XLEN-1 -: 4] = TT_ADDR;
    c2[6:0] = wdata_i[6:0] & 7'h5F;
    if (size_ok(size2)) begin
      c2[17:16] = size2[1:0];
      if (XLEN == 64) c2[22:21] = size2[3:2];
    end

    c6 = '0;
    c6[XLEN-1 -: 4] = TT_ADDR6;
    c6[24:23] = wdata_i[24:23];
    c6[6:0] = wdata_i[6:0] & 7'h5F;
    if (size_ok(size6)) c6[19:16] = size6;

    c3 = '0;
    c3[XLEN-1 -: 4] = TT_ICNT;
    c3[26:25] = wdata_i[26:25];
    c3[23:10] = wdata_i[23:10];
    c3[9]     = wdata_i[9];
    c3[7:6]   = wdata_i[7:6];
  end

  always_comb begin
    ctrl_ok_o = 1'b1;
    unique case (wtype)
      TT_ADDR:  ctrl_o = c2;
      TT_ADDR6: ctrl_o = c6;
      TT_ICNT:  ctrl_o = c3;
      default: begin
        ctrl_o    = '0;
        ctrl_ok_o = 1'b0;
      end
    endcase
  end

  always_comb begin
    extra_o = '0;
    extra_o[XLEN-1:MHV] = wdata_i[XLEN-1:MHV];
    extra_o[MHS+2]      = wdata_i[MHS+2];
  end
endmodule

// File: rtl/dbg_trig_slot.sv
module dbg_trig_slot
  import dbg_trig_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_ctrl_i,
  input  logic            ctrl_ok_i,
  input  logic [XLEN-1:0] ctrl_val_i,
  input  logic            we_addr_i,
  input  logic [XLEN-1:0] addr_val_i,
  input  logic            we_extr_i,
  input  logic [XLEN-1:0] extr_val_i,
  output logic [XLEN-1:0] ctrl_o,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] extra_o
);
  localparam int MHS = mhs_lo(XLEN);
  localparam logic [XLEN-1:0] CTRL_RST = {TT_ADDR, {(XLEN-4){1'b0}}};

  logic [XLEN-1:0] ctrl_q, addr_q, extr_q;
  logic [3:0]      cur_type;

  assign cur_type = ctrl_q[XLEN-1 -: 4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      addr_q <= '0;
      extr_q <= '0;
    end else begin
      if (we_ctrl_i && ctrl_ok_i)              ctrl_q <= ctrl_val_i;
      if (we_addr_i && cur_type != TT_ICNT)    addr_q <= addr_val_i;
      if (we_extr_i)                           extr_q <= extr_val_i;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign addr_o  = addr_q;
  assign extra_o = extr_q;

  // R7
  type_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_type == TT_ADDR || cur_type == TT_ADDR6 || cur_type == TT_ICNT);
  // R7
  bad_type_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_ctrl_i && !ctrl_ok_i) |=> $stable(ctrl_q));
  // R4
  dmode_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[XLEN-5] == 1'b0);
  // R6
  icnt_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_addr_i && cur_type == TT_ICNT) |=> $stable(addr_q));
  // R8
  mhsel_fold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    extr_q[MHS+1:MHS] == 2'b00);
endmodule

// File: rtl/dbg_trig_bank.sv
module dbg_trig_bank
  import dbg_trig_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_TRIG = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [11:0]              csr_addr_i,
  input  logic                     csr_we_i,
  input  logic [XLEN-1:0]          csr_wdata_i,
  output logic [XLEN-1:0]          csr_rdata_o,
  output logic [NUM_TRIG*XLEN-1:0] trig_ctrl_o,
  output logic [NUM_TRIG*XLEN-1:0] trig_addr_o,
  output logic [NUM_TRIG*XLEN-1:0] trig_extra_o
);
  localparam int SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  logic [SEL_W-1:0] sel_q;
  logic [XLEN-1:0]  ctrl_leg, extr_leg;
  logic             ctrl_ok;
  logic             sel_wr;
  logic [XLEN-1:0]  ctrl_a  [NUM_TRIG];
  logic [XLEN-1:0]  addr_a  [NUM_TRIG];
  logic [XLEN-1:0]  extr_a  [NUM_TRIG];

  assign sel_wr = csr_we_i && csr_addr_i == A_SEL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (sel_wr && csr_wdata_i < XLEN'(NUM_TRIG)) sel_q <= csr_wdata_i[SEL_W-1:0];
  end

  dbg_trig_legalize #(.XLEN(XLEN)) u_leg (
    .wdata_i   (csr_wdata_i),
    .ctrl_o    (ctrl_leg),
    .ctrl_ok_o (ctrl_ok),
    .extra_o   (extr_leg)
  );

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_slot
    logic hit;
    assign hit = csr_we_i && (sel_q == SEL_W'(i));
    dbg_trig_slot #(.XLEN(XLEN)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_ctrl_i  (hit && csr_addr_i == A_CTRL),
      .ctrl_ok_i  (ctrl_ok),
      .ctrl_val_i (ctrl_leg),
      .we_addr_i  (hit && csr_addr_i == A_ADDR),
      .addr_val_i (csr_wdata_i),
      .we_extr_i  (hit && csr_addr_i == A_EXTR),
      .extr_val_i (extr_leg),
      .ctrl_o     (ctrl_a[i]),
      .addr_o     (addr_a[i]),
      .extra_o    (extr_a[i])
    );
    assign trig_ctrl_o[i*XLEN +: XLEN]  = ctrl_a[i];
    assign trig_addr_o[i*XLEN +: XLEN]  = addr_a[i];
    assign trig_extra_o[i*XLEN +: XLEN] = extr_a[i];
  end

  always_comb begin
    unique case (csr_addr_i)
      A_SEL:   csr_rdata_o = XLEN'(sel_q);
      A_CTRL:  csr_rdata_o = ctrl_a[sel_q];
      A_ADDR:  csr_rdata_o = addr_a[sel_q];
      A_EXTR:  csr_rdata_o = extr_a[sel_q];
      A_INFO:  csr_rdata_o = XLEN'(INFO_VAL);
      default: csr_rdata_o = '0;
    endcase
  end

  // R2
  sel_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(sel_q) < NUM_TRIG);
  // R2
  sel_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr && csr_wdata_i >= XLEN'(NUM_TRIG)) |=> $stable(sel_q));
endmodule

// File: tb/dbg_trig_bank_test.sv
module dbg_trig_bank_test;
  localparam int XLEN = 32;
  localparam int NT   = 2;

  localparam logic [11:0] SEL = 12'h7A0, CTL = 12'h7A1, ADR = 12'h7A2,
                          EXT = 12'h7A3, INF = 12'h7A4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic we = 1'b0;
  logic [XLEN-1:0] wdata = '0, rdata;
  logic [NT*XLEN-1:0] ctrl_x, addr_x, extr_x;

  always #2.5 clk = ~clk;

  dbg_trig_bank #(.XLEN(XLEN), .NUM_TRIG(NT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_we_i(we),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .trig_ctrl_o(ctrl_x), .trig_addr_o(addr_x), .trig_extra_o(extr_x));

  typedef struct {
    int          kind;   // 0 read data, 1 ctrl export, 2 addr export, 3 extra export
    int          idx;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0, fails = 0;
  bit done = 0;

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a; we = 1'b0;
    it.kind = 0; it.idx = 0; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic ex(input int k, input int i, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    we = 1'b0;
    it.kind = k; it.idx = i; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          1: act = ctrl_x[it.idx*XLEN +: XLEN];
          2: act = addr_x[it.idx*XLEN +: XLEN];
          3: act = extr_x[it.idx*XLEN +: XLEN];
          default: act = rdata;
        endcase
        total++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(SEL, 32'h0, "R1 sel");
    rd(CTL, 32'h2000_0000, "R1 ctrl");
    rd(ADR, 32'h0, "R1 addr");
    rd(EXT, 32'h0, "R1 extra");
    ex(1, 1, 32'h2000_0000, "R1 ctrl export t1");
    // R3
    rd(INF, 32'h44, "R3 info");
    // R2 select range
    wr(SEL, 1);            rd(SEL, 32'h1, "R2 select 1");
    wr(SEL, 2);            rd(SEL, 32'h1, "R2 out of range 2");
    wr(SEL, 32'hFFFF_FFFF); rd(SEL, 32'h1, "R2 out of range max");
    wr(SEL, 0);            rd(SEL, 32'h0, "R2 select 0");
    // R3 write ignored
    wr(INF, 32'h0);        rd(INF, 32'h44, "R3 info after write");
    // R4 type 2 legalization
    wr(CTL, 32'h2FFF_FFFF); rd(CTL, 32'h2003_005F, "R4 all ones");
    wr(CTL, 32'h2800_0000); rd(CTL, 32'h2000_0000, "R4 dmode dropped");
    // R9
    wr(ADR, 32'hDEAD_BEEF); rd(ADR, 32'hDEAD_BEEF, "R9 addr stored");
    // R5 type 6 sizes
    wr(CTL, 32'h6FFF_FFFF); rd(CTL, 32'h6180_005F, "R5 type6 ones size15");
    wr(CTL, 32'h6005_0000); rd(CTL, 32'h6005_0000, "R5 size 8B kept");
    wr(CTL, 32'h6004_0041); rd(CTL, 32'h6000_0041, "R5 size 6B dropped");
    wr(CTL, 32'h6003_0000); rd(CTL, 32'h6003_0000, "R5 size 4B kept");
    // R7 unsupported types dropped
    wr(CTL, 32'h5000_00FF); rd(CTL, 32'h6003_0000, "R7 type5");
    wr(CTL, 32'h0000_00FF); rd(CTL, 32'h6003_0000, "R7 type0");
    wr(CTL, 32'hF000_0000); rd(CTL, 32'h6003_0000, "R7 type15");
    // R6 instruction count
    wr(CTL, 32'h3FFF_FFFF); rd(CTL, 32'h36FF_FEC0, "R6 icount ones");
    wr(ADR, 32'h1234_5678); rd(ADR, 32'hDEAD_BEEF, "R6 addr write ignored");
    // R8 extra word
    wr(EXT, 32'hFFFF_FFFF); rd(EXT, 32'hFE00_0000, "R8 ones");
    wr(EXT, 32'h0380_0000); rd(EXT, 32'h0200_0000, "R8 sel7 to 4");
    wr(EXT, 32'h0180_0000); rd(EXT, 32'h0000_0000, "R8 sel3 to 0");
    wr(EXT, 32'h0400_0000); rd(EXT, 32'h0400_0000, "R8 value kept");
    // R10 per-trigger writes and exports
    wr(SEL, 1);
    wr(CTL, 32'h2000_0041);
    wr(ADR, 32'hCAFE_0000);
    ex(1, 1, 32'h2000_0041, "R10 ctrl export t1");
    ex(2, 1, 32'hCAFE_0000, "R10 addr export t1");
    ex(1, 0, 32'h36FF_FEC0, "R10 ctrl export t0");
    ex(2, 0, 32'hDEAD_BEEF, "R10 addr export t0");
    ex(3, 0, 32'h0400_0000, "R10 extra export t0");
    ex(3, 1, 32'h0000_0000, "R10 extra export t1");
    // R11 back-to-back type change then address write
    wr(CTL, 32'h3000_0000);
    wr(ADR, 32'h1111_1111);
    rd(ADR, 32'hCAFE_0000, "R11 icount blocks next addr write");
    wr(CTL, 32'h2000_0000);
    wr(ADR, 32'h2222_2222);
    rd(ADR, 32'h2222_2222, "R11 type2 accepts next addr write");
    rd(CTL, 32'h2000_0000, "R11 ctrl after switch");
    @(negedge clk);
    we = 1'b0;
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule